// File: doc/BRIEF.md
# Accumulator Store Rounder and Saturator

This block turns a wide signed accumulator value into one 1.15 fractional word ready to be written to data memory. The accumulator is split into a high part, the bits above the stored word's fraction, and a low part, the bits below it. The high part is either taken as it is (truncation) or rounded by a one-LSB increment. Rounding is either conventional, where an exact half always rounds up, or convergent, where an exact half rounds to the even neighbour.

After rounding, an optional store saturation clamps anything outside the 1.15 range to the largest positive or most negative word. The sign used for that test is the accumulator's top bit, taken before rounding, so a carry that the increment pushes into the top bit cannot flip the decision. The source accumulator is only read. The rounder and the saturator are combinational. One output register presents the word with a valid flag on the cycle after the request.

With default parameters the accumulator is 40 bits, the word is 16 bits, and the rounded high part is 24 bits (bits 39:16).

Top module: `acc_store_conv`

## Requirements
- R1: With `rnd_en_i` low, `word_o` equals accumulator bits [WORD_W*2-1:WORD_W] (bits 31:16 by default), unless store saturation clamps it. The low word is discarded.
- R2: With `rnd_en_i` high and `rnd_conv_i` low (conventional), the high part (bits 39:16) is incremented exactly when accumulator bit WORD_W-1 (bit 15) is 1.
- R3: With `rnd_en_i` high and `rnd_conv_i` high (convergent), a low word equal to exactly half (0x8000) increments the high part only when accumulator bit WORD_W (bit 16) is 1. The resulting word's LSB is therefore 0.
- R4: In convergent mode, any low word other than exactly half rounds the same way as conventional mode.
- R5: With `sat_en_i` high and accumulator bit 39 equal to 0, a rounded high part above 0x007FFF, including a wrap into bit 23, stores as 0x7FFF.
- R6: With `sat_en_i` high and accumulator bit 39 equal to 1, a rounded high part below 0xFF8000 stores as 0x8000.
- R7: The saturation sign is accumulator bit 39 before rounding. A negative value that rounds up to 0x000000 stores as 0x0000 and is not clamped.
- R8: With `sat_en_i` low, `word_o` is the low 16 bits of the rounded or truncated high part, with wraparound and no clamping.
- R9: `valid_o` is high in exactly the cycle after a cycle with `req_i` high, and `word_o` then carries that request's result.
- R10: After reset, `valid_o` is 0 and `word_o` is 0. In any cycle after one with `req_i` low, `word_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Convert and store request |
| acc_i | input | ACC_W | Source accumulator value (signed) |
| rnd_en_i | input | 1 | 1: round, 0: truncate |
| rnd_conv_i | input | 1 | Rounding mode: 0 conventional, 1 convergent |
| sat_en_i | input | 1 | Store saturation enable |
| valid_o | output | 1 | Result valid, one cycle after request |
| word_o | output | WORD_W | Stored 1.15 word |

## Verification
The bench builds the block with ACC_W=10 and WORD_W=4. This keeps every width relation of the default configuration: a guard field above the stored word, a low word of the same width, and the threshold at half of the word range. At that size all 1024 accumulator values can be driven under all eight combinations of round enable, rounding mode and saturation enable.

The sweep therefore reaches every exact-half tie with both parities of bit WORD_W. It also reaches the positive wrap into the top bit and the negative rounding up to zero, and it covers both saturation thresholds from either side. Expected words come from integer arithmetic on the signed accumulator value.

// File: rtl/acc_store_pkg.sv
package acc_store_pkg;
  typedef enum logic {
    RND_CONVENTIONAL = 1'b0,
    RND_CONVERGENT   = 1'b1
  } rnd_mode_e;
endpackage

// File: rtl/acc_rounder.sv
module acc_rounder
  import acc_store_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int WORD_W = 16,
  localparam int HI_W  = ACC_W - WORD_W
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic             rnd_en_i,
  input  rnd_mode_e        mode_i,
  output logic [HI_W-1:0]  rounded_o
);
  logic [WORD_W-1:0] lo;
  logic [HI_W-1:0]   hi;
  logic              half, rest_nz, tie, inc;

  assign lo      = acc_i[WORD_W-1:0];
  assign hi      = acc_i[ACC_W-1:WORD_W];
  assign half    = lo[WORD_W-1];
  assign rest_nz = |lo[WORD_W-2:0];
  assign tie     = half & ~rest_nz;

  // convergent: exact half goes to the even neighbour
  always_comb begin
    inc = 1'b0;
    if (rnd_en_i) begin
      if (mode_i == RND_CONVERGENT) inc = half & (rest_nz | hi[0]);
      else                          inc = half;
    end
  end

  assign rounded_o = hi + HI_W'(inc);

  always_comb begin
    if (rnd_en_i && mode_i == RND_CONVERGENT && tie)
      p_tie_even_r3: assert (rounded_o[0] == 1'b0);
    if (!rnd_en_i)
      p_trunc_keeps_hi_r1: assert (rounded_o == hi);
  end
endmodule

// File: rtl/acc_store_sat.sv
module acc_store_sat #(
  parameter int HI_W   = 24,
  parameter int WORD_W = 16,
  localparam int TOP_W = HI_W - WORD_W + 1
) (
  input  logic              sign_i,
  input  logic [HI_W-1:0]   val_i,
  input  logic              sat_en_i,
  output logic [WORD_W-1:0] word_o,
  output logic              sat_hit_o
);
  localparam logic [WORD_W-1:0] MAX_WORD = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] MIN_WORD = {1'b1, {(WORD_W-1){1'b0}}};

  logic [TOP_W-1:0] top_bits;
  logic             pos_ovf, neg_ovf;

  assign top_bits = val_i[HI_W-1:WORD_W-1];
  // positive side also catches a rounding carry into the top bit
  assign pos_ovf  = ~sign_i & (|top_bits);
  // negative side ignores a rounding wrap up to zero
  assign neg_ovf  = sign_i & val_i[HI_W-1] & ~(&top_bits);

  assign sat_hit_o = sat_en_i & (pos_ovf | neg_ovf);

  always_comb begin
    word_o = val_i[WORD_W-1:0];
    if (sat_en_i && pos_ovf) word_o = MAX_WORD;
    if (sat_en_i && neg_ovf) word_o = MIN_WORD;
  end

  always_comb begin
    if (sat_en_i && !sign_i)
      p_pos_nonneg_r5: assert (word_o[WORD_W-1] == 1'b0);
    if (sat_en_i && sign_i && val_i[HI_W-1])
      p_neg_stays_neg_r6: assert (word_o[WORD_W-1] == 1'b1);
  end
endmodule

// File: rtl/acc_store_reg.sv
module acc_store_reg #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] d_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      q_o     <= '0;
    end else begin
      valid_o <= load_i;
      if (load_i) q_o <= d_i;
    end
  end
endmodule

// File: rtl/acc_store_conv.sv
module acc_store_conv
  import acc_store_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic              rnd_en_i,
  input  logic              rnd_conv_i,
  input  logic              sat_en_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int HI_W = ACC_W - WORD_W;
  localparam logic [WORD_W-1:0] MAX_WORD = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] MIN_WORD = {1'b1, {(WORD_W-1){1'b0}}};

  rnd_mode_e         mode;
  logic [HI_W-1:0]   rounded;
  logic [WORD_W-1:0] next_word;
  logic              sat_hit;

  assign mode = rnd_mode_e'(rnd_conv_i);

  acc_rounder #(.ACC_W(ACC_W), .WORD_W(WORD_W)) u_rounder (
    .acc_i     (acc_i),
    .rnd_en_i  (rnd_en_i),
    .mode_i    (mode),
    .rounded_o (rounded)
  );

  acc_store_sat #(.HI_W(HI_W), .WORD_W(WORD_W)) u_sat (
    .sign_i    (acc_i[ACC_W-1]),
    .val_i     (rounded),
    .sat_en_i  (sat_en_i),
    .word_o    (next_word),
    .sat_hit_o (sat_hit)
  );

  acc_store_reg #(.WORD_W(WORD_W)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (req_i),
    .d_i     (next_word),
    .valid_o (valid_o),
    .q_o     (word_o)
  );

  p_valid_follows_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  p_idle_no_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);
  p_hold_word_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(word_o));
  p_sat_pos_word_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && sat_hit && !acc_i[ACC_W-1]) |=> word_o == MAX_WORD);
  p_sat_neg_word_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && sat_hit && acc_i[ACC_W-1]) |=> word_o == MIN_WORD);
endmodule

// File: tb/acc_store_conv_bench.sv
module acc_store_conv_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ACC_W  = 10;
  localparam int WORD_W = 4;
  localparam int NACC   = 1 << ACC_W;
  localparam int LO_N   = 1 << WORD_W;
  localparam int HALF   = LO_N / 2;
  localparam int WMAX   = HALF - 1;
  localparam int WMIN   = -HALF;
  localparam int HI_SPAN = 1 << (ACC_W - WORD_W);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0;
  logic [ACC_W-1:0]  acc = '0;
  logic              rnd_en = 1'b0, rnd_conv = 1'b0, sat_en = 1'b0;
  logic              valid;
  logic [WORD_W-1:0] word;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_store_conv #(.ACC_W(ACC_W), .WORD_W(WORD_W)) u_acc_store_conv (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .acc_i(acc),
    .rnd_en_i(rnd_en), .rnd_conv_i(rnd_conv), .sat_en_i(sat_en),
    .valid_o(valid), .word_o(word)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // rounded high part as a signed integer, before wrap
  function automatic int model_hi(input int a, input bit en, input bit conv);
    int v, lo, hi;
    v  = (a >= NACC/2) ? a - NACC : a;
    lo = a % LO_N;
    hi = (v - lo) / LO_N;
    if (en) begin
      if (lo > HALF) hi++;
      else if (lo == HALF) begin
        if (!conv || (hi & 1) != 0) hi++;
      end
    end
    return hi;
  endfunction

  function automatic int model_word(input int a, input bit en, input bit conv, input bit sat);
    int hi;
    hi = model_hi(a, en, conv);
    if (sat && hi > WMAX) return WMAX;
    if (sat && hi < WMIN) return WMIN & (LO_N - 1);
    return hi & (LO_N - 1);
  endfunction

  function automatic string tag_of(input int a, input bit en, input bit conv, input bit sat);
    int hi;
    bit neg;
    string t;
    hi  = model_hi(a, en, conv);
    neg = a >= NACC/2;
    if      (!en)                      t = "R1";
    else if (conv && a % LO_N == HALF) t = "R3";
    else if (conv)                     t = "R4";
    else                               t = "R2";
    if (!sat)                    t = {t, "/R8"};
    else if (hi > WMAX)          t = {t, "/R5"};
    else if (hi < WMIN)          t = {t, "/R6"};
    if (neg && hi == 0)          t = {t, "/R7"};
    else if (!neg && hi == HI_SPAN/2) t = {t, "/R7"};
    return t;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [WORD_W-1:0] held;
    repeat (3) @(negedge clk);
    check("R10 reset valid", int'(valid), 0);
    check("R10 reset word", int'(word), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle valid", int'(valid), 0);

    for (int m = 0; m < 8; m++) begin
      for (int a = 0; a < NACC; a++) begin
        acc      = ACC_W'(a);
        rnd_en   = m[0];
        rnd_conv = m[1];
        sat_en   = m[2];
        req      = 1'b1;
        @(negedge clk);
        check({tag_of(a, m[0], m[1], m[2]), " word"}, int'(word),
              model_word(a, m[0], m[1], m[2]));
        if (!valid) check("R9 valid after req", int'(valid), 1);
      end
    end

    // idle cycles: word holds, valid drops
    held = word;
    req  = 1'b0;
    acc  = ACC_W'(NACC/2 - 1);
    sat_en = 1'b1;
    @(negedge clk);
    check("R9 valid drops", int'(valid), 0);
    check("R10 word held", int'(word), int'(held));
    acc = '0;
    @(negedge clk);
    check("R10 word held 2", int'(word), int'(held));

    // single request after idle
    acc = ACC_W'(HALF);
    rnd_en = 1'b1; rnd_conv = 1'b1; sat_en = 1'b0;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check("R3 tie to even zero", int'(word), 0);
    check("R9 valid single", int'(valid), 1);
    @(negedge clk);
    check("R9 valid single drop", int'(valid), 0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule